// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small serial nonvolatile memory that answers on a chip select, a serial clock, a data input and a data output. The memory holds `WORDS` words of `WIDTH` bits each, 64 by 16 by default, in ordinary registers. All pins are sampled in the system clock domain. The serial clock must run several system clocks per phase.

Each transaction begins when chip select goes high. The first 1 seen on the data input is the start bit. It is followed by a two-bit operation field and an address field. Depending on the operation, the block then returns a word, takes in a word, or starts a programming job. A programming job is an erase, a write, a whole-array erase or a whole-array fill.

Programming takes a configurable number of system clocks. While chip select is high during or after a job, the data output shows the job's status: low means busy and high means ready. An internal write-enable latch must be set before any command that modifies memory will act.

Top module: `eep_serial_mem`

## Requirements
- R1: Operation field `10` (read) returns the addressed word most significant bit first. Bit D(15-i) is valid on `dout`, with `dout_en` high, before serial rising edge 10+i. Edges are counted from the start bit, which is edge 1.
- R2: Operation field `01` (write) takes 16 data bits, most significant first, on edges 10 to 25. When the write-enable latch is set, the addressed word holds that value once the job completes.
- R3: Operation field `11` (erase) sets the addressed word to all ones when the write-enable latch is set.
- R4: Operation field `00` takes a sub-command from the top two address bits, and the low four address bits have no effect. The sub-commands are: `11` sets the latch, `00` clears it, `10` sets every word to all ones, and `01` loads 16 following data bits into every word. Latch commands and reads drive no status.
- R5: Reset clears the write-enable latch. While the latch is clear, write, erase, erase-all and write-all change no word and drive no status.
- R6: After an accepted modifying command, `dout` is driven low while chip select is high for `T_WRITE`, `T_ERASE` or `T_BULK` cycles, then driven high until chip select falls. This status also shows if chip select is raised again while the job is still running.
- R7: While chip select is low, and whenever the block is not driving, `dout_en` is low and `dout` reads high through the modelled pull-up. This is the state after reset.
- R8: If chip select falls before the last bit of a command arrives, the command is dropped and memory is unchanged.
- R9: Zeros received after chip select rises and before the first 1 are ignored. The first 1 is taken as the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial data input |
| dout | output | 1 | Serial data output level, pulled high when not driven |
| dout_en | output | 1 | High while the block drives `dout` |

## Verification
The hardest case to reach is the status output after chip select has been dropped and raised again while a job is still counting down. The bench issues a write, lowers chip select right after the last data bit, reselects at once and expects busy, then ready. A second hard case is the disabled-latch path, because its effect shows only in later reads. Those reads follow the latch-clear command and are compared against a behavioural memory image. Aborted commands are cut off mid-data, and the affected word is read back afterwards.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    OP_MODE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_CLEAR  = 2'b10,
    SUB_UNLOCK = 2'b11
  } sub_e;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_SKIP,
    ST_PROG
  } st_e;
endpackage

// File: rtl/eep_pin_sampler.sv
module eep_pin_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic cs_q,
  output logic bit_ok,
  output logic bit_v
);
  logic sck_r, sck_d, di_r, cs_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_r  <= 1'b0;
      sck_r <= 1'b0;
      sck_d <= 1'b0;
      di_r  <= 1'b0;
    end else begin
      cs_r  <= cs;
      sck_r <= sck;
      sck_d <= sck_r;
      di_r  <= di;
    end
  end

  assign cs_q   = cs_r;
  assign bit_ok = cs_r & sck_r & ~sck_d;
  assign bit_v  = di_r;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int WORDS = 64,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= load;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/eep_serial_mem.sv
module eep_serial_mem
  import eep_pkg::*;
#(
  parameter int WORDS   = 64,
  parameter int WIDTH   = 16,
  parameter int T_WRITE = 200,
  parameter int T_ERASE = 100,
  parameter int T_BULK  = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic dout,
  output logic dout_en
);
  localparam int AW       = $clog2(WORDS);
  localparam int CMD_BITS = 2 + AW;
  localparam int DATA_END = CMD_BITS + WIDTH;
  localparam int T_MAX    = (T_BULK > T_WRITE) ? ((T_BULK > T_ERASE) ? T_BULK : T_ERASE)
                                               : ((T_WRITE > T_ERASE) ? T_WRITE : T_ERASE);
  localparam int CW       = $clog2(T_MAX + 1);
  localparam int NW       = $clog2(DATA_END + 1);
  localparam logic [NW-1:0] CMD_LAST  = NW'(CMD_BITS - 1);
  localparam logic [NW-1:0] DATA_LAST = NW'(DATA_END - 1);

  logic cs_q, bit_ok, bit_v;
  st_e  st;
  logic [NW-1:0]       cnt;
  logic [CMD_BITS-2:0] cmd_q;
  logic [WIDTH-2:0]    dat_q;
  logic [AW-1:0]       addr_q;
  logic                fill_q, wen_q, ld1, ld2;
  logic [WIDTH-1:0]    out_sr, rdata;
  logic                busy;

  logic [CMD_BITS-1:0] cmd_full;
  logic [WIDTH-1:0]    dat_full;
  op_e                 op_now;
  sub_e                sub_now;
  logic [AW-1:0]       addr_now;
  logic                at_cmd_end, at_dat_end;

  logic                prog_go, job_fill;
  logic [CW-1:0]       prog_load;
  logic [WIDTH-1:0]    job_val;
  logic [AW-1:0]       job_addr;

  logic                sw_on;
  logic [AW-1:0]       sw_idx, sw_end;
  logic [WIDTH-1:0]    wr_val;

  eep_pin_sampler u_pins (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .di(di),
    .cs_q(cs_q), .bit_ok(bit_ok), .bit_v(bit_v)
  );

  eep_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(sw_on), .waddr(sw_idx), .wdata(wr_val),
    .raddr(addr_q), .rdata(rdata)
  );

  eep_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .start(prog_go), .load(prog_load), .busy(busy)
  );

  // Command field decode from the bit arriving on this edge
  always_comb begin
    cmd_full   = {cmd_q, bit_v};
    dat_full   = {dat_q, bit_v};
    op_now     = op_e'(cmd_full[CMD_BITS-1 -: 2]);
    sub_now    = sub_e'(cmd_full[AW-1 -: 2]);
    addr_now   = cmd_full[AW-1:0];
    at_cmd_end = bit_ok && (st == ST_CMD)  && (cnt == CMD_LAST);
    at_dat_end = bit_ok && (st == ST_DATA) && (cnt == DATA_LAST);
  end

  // Programming job launch, gated by the write-enable latch
  always_comb begin
    prog_go   = 1'b0;
    prog_load = '0;
    job_fill  = 1'b0;
    job_val   = '1;
    job_addr  = addr_now;
    if (wen_q && at_cmd_end && op_now == OP_ERASE) begin
      prog_go   = 1'b1;
      prog_load = CW'(T_ERASE);
    end else if (wen_q && at_cmd_end && op_now == OP_MODE && sub_now == SUB_CLEAR) begin
      prog_go   = 1'b1;
      prog_load = CW'(T_BULK);
      job_fill  = 1'b1;
    end else if (wen_q && at_dat_end) begin
      prog_go   = 1'b1;
      prog_load = fill_q ? CW'(T_BULK) : CW'(T_WRITE);
      job_fill  = fill_q;
      job_val   = dat_full;
      job_addr  = addr_q;
    end
  end

  // Serial command sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_HUNT;
      cnt    <= '0;
      cmd_q  <= '0;
      dat_q  <= '0;
      addr_q <= '0;
      fill_q <= 1'b0;
      wen_q  <= 1'b0;
      ld1    <= 1'b0;
      ld2    <= 1'b0;
      out_sr <= '1;
    end else begin
      ld1 <= 1'b0;
      ld2 <= ld1;
      if (ld2) out_sr <= rdata;
      if (!cs_q) begin
        cnt <= '0;
        if (!(st == ST_PROG && busy)) st <= ST_HUNT;
      end else if (bit_ok) begin
        case (st)
          ST_HUNT: if (bit_v) begin
            st  <= ST_CMD;
            cnt <= '0;
          end
          ST_CMD: begin
            cmd_q <= cmd_full[CMD_BITS-2:0];
            cnt   <= cnt + 1'b1;
            if (cnt == CMD_LAST) begin
              addr_q <= addr_now;
              case (op_now)
                OP_READ: begin
                  ld1 <= 1'b1;
                  st  <= ST_READ;
                end
                OP_WRITE: begin
                  fill_q <= 1'b0;
                  st     <= ST_DATA;
                end
                OP_ERASE: st <= prog_go ? ST_PROG : ST_SKIP;
                default: begin
                  case (sub_now)
                    SUB_UNLOCK: begin wen_q <= 1'b1; st <= ST_SKIP; end
                    SUB_LOCK:   begin wen_q <= 1'b0; st <= ST_SKIP; end
                    SUB_CLEAR:  st <= prog_go ? ST_PROG : ST_SKIP;
                    default:    begin fill_q <= 1'b1; st <= ST_DATA; end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            dat_q <= dat_full[WIDTH-2:0];
            cnt   <= cnt + 1'b1;
            if (cnt == DATA_LAST) st <= prog_go ? ST_PROG : ST_SKIP;
          end
          ST_READ: begin
            out_sr <= {out_sr[WIDTH-2:0], 1'b1};
            cnt    <= cnt + 1'b1;
            if (cnt == DATA_LAST) st <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // Word sweep: one word for single jobs, every word for bulk jobs
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_on  <= 1'b0;
      sw_idx <= '0;
      sw_end <= '0;
      wr_val <= '1;
    end else if (prog_go) begin
      sw_on  <= 1'b1;
      sw_idx <= job_fill ? '0 : job_addr;
      sw_end <= job_fill ? AW'(WORDS - 1) : job_addr;
      wr_val <= job_val;
    end else if (sw_on) begin
      if (sw_idx == sw_end) sw_on <= 1'b0;
      else                  sw_idx <= sw_idx + 1'b1;
    end
  end

  // Registered pin outputs with modelled pull-up
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= 1'b0;
      dout    <= 1'b1;
    end else begin
      dout_en <= cs_q && (st == ST_READ || st == ST_PROG);
      if (cs_q && st == ST_PROG)      dout <= ~busy;
      else if (cs_q && st == ST_READ) dout <= out_sr[WIDTH-1];
      else                            dout <= 1'b1;
    end
  end
endmodule

// File: rtl/eep_serial_mem_chk.sv
module eep_serial_mem_chk (
  input logic clk,
  input logic rst,
  input logic cs_q,
  input logic dout_en,
  input logic wen,
  input logic prog_go,
  input logic mem_we,
  input logic busy
);
  AST_RELEASE_DESELECTED: assert property (@(posedge clk) disable iff (rst) !cs_q |=> !dout_en); // R7
  AST_LATCH_GATES_PROG:   assert property (@(posedge clk) disable iff (rst) prog_go |-> wen); // R5
  AST_BUSY_AFTER_GO:      assert property (@(posedge clk) disable iff (rst) prog_go |=> busy); // R6
  AST_WRITE_WHILE_BUSY:   assert property (@(posedge clk) disable iff (rst) mem_we |-> busy); // R6
  AST_GO_NEEDS_SELECT:    assert property (@(posedge clk) disable iff (rst) prog_go |-> cs_q); // R8
endmodule

bind eep_serial_mem eep_serial_mem_chk u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .dout_en(dout_en),
  .wen(wen_q), .prog_go(prog_go), .mem_we(sw_on), .busy(busy)
);

// File: tb/eep_serial_mem_test.sv
module eep_serial_mem_test;
  localparam int TW = 200;
  localparam int TE = 100;
  localparam int TB = 600;
  localparam int H  = 4;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic dout, dout_en;
  int n_cmp = 0, n_bad = 0, cs_low = 0;
  bit finished = 1'b0;
  bit ref_wen = 1'b0;
  logic [15:0] ref_mem [64];

  always #5 clk = ~clk;

  eep_serial_mem #(.WORDS(64), .WIDTH(16), .T_WRITE(TW), .T_ERASE(TE), .T_BULK(TB)) uut (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .di(di), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cs_low <= cs ? 0 : cs_low + 1;

  // Per-clock comparison of the pin model (R7)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (!dout_en) chk("R7 pull-up level", dout, 1);
      if (cs_low >= 3) chk("R7 released when deselected", dout_en, 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic s);
    di = b; sck = 1'b0; cyc(H);
    s = dout; sck = 1'b1; cyc(H);
  endtask

  task automatic open_sel();
    sck = 1'b0; cs = 1'b1; cyc(H);
  endtask

  task automatic close_sel();
    sck = 1'b0; cs = 1'b0; cyc(H + 2);
  endtask

  task automatic send9(input logic [1:0] op, input logic [5:0] a);
    logic s;
    sbit(1'b1, s);
    for (int i = 1; i >= 0; i--) sbit(op[i], s);
    for (int i = 5; i >= 0; i--) sbit(a[i], s);
  endtask

  task automatic send16(input logic [15:0] d);
    logic s;
    for (int i = 15; i >= 0; i--) sbit(d[i], s);
  endtask

  task automatic rd_word(input logic [5:0] a, output logic [15:0] v);
    logic s;
    open_sel();
    send9(2'b10, a);
    for (int i = 15; i >= 0; i--) begin sbit(1'b0, s); v[i] = s; end
    close_sel();
  endtask

  task automatic check_read(input string tag, input logic [5:0] a);
    logic [15:0] v;
    rd_word(a, v);
    chk(tag, v, ref_mem[a]);
  endtask

  task automatic expect_status(input string tag, input int t);
    int k;
    chk({tag, " status driven"}, dout_en, 1);
    chk({tag, " busy low"}, dout, 0);
    cyc(t - H - 12);
    chk({tag, " still busy"}, dout, 0);
    k = 0;
    while (dout !== 1'b1 && k < 40) begin cyc(1); k++; end
    chk({tag, " ready high"}, dout, 1);
    chk({tag, " ready in time"}, (k < 40), 1);
    close_sel();
  endtask

  task automatic expect_none(input string tag);
    cyc(6);
    chk({tag, " no status"}, dout_en, 0);
    close_sel();
  endtask

  task automatic cmd_latch(input logic on, input logic [3:0] junk);
    open_sel();
    send9(2'b00, {on, on, junk});
    close_sel();
    ref_wen = on;
  endtask

  task automatic cmd_erase(input logic [5:0] a);
    open_sel();
    send9(2'b11, a);
    if (ref_wen) begin expect_status("R3 R6 erase", TE); ref_mem[a] = 16'hFFFF; end
    else expect_none("R5 erase locked");
  endtask

  task automatic cmd_write(input logic [5:0] a, input logic [15:0] d);
    open_sel();
    send9(2'b01, a);
    send16(d);
    if (ref_wen) begin expect_status("R2 R6 write", TW); ref_mem[a] = d; end
    else expect_none("R5 write locked");
  endtask

  task automatic cmd_eral(input logic [3:0] junk);
    open_sel();
    send9(2'b00, {2'b10, junk});
    if (ref_wen) begin
      expect_status("R4 R6 erase-all", TB);
      for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
    end else expect_none("R5 erase-all locked");
  endtask

  task automatic cmd_wral(input logic [3:0] junk, input logic [15:0] d);
    open_sel();
    send9(2'b00, {2'b01, junk});
    send16(d);
    if (ref_wen) begin
      expect_status("R4 R6 write-all", TB);
      for (int i = 0; i < 64; i++) ref_mem[i] = d;
    end else expect_none("R5 write-all locked");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic s;
    cyc(5);
    rst = 1'b0;
    cyc(2);
    chk("R7 reset dout_en", dout_en, 0);
    chk("R7 reset dout", dout, 1);

    // R5: latch clear after reset
    cmd_write(6'd3, 16'h1234);
    cmd_latch(1'b1, 4'b0101);          // R4 low bits don't care
    cmd_eral(4'b1001);
    check_read("R4 erase-all word 0", 6'd0);
    check_read("R4 erase-all word 37", 6'd37);
    check_read("R4 erase-all word 63", 6'd63);

    cmd_write(6'd3, 16'hA5C3);
    check_read("R1 R2 read word 3", 6'd3);
    check_read("R2 neighbour 4 untouched", 6'd4);
    cmd_write(6'd40, 16'h0F0F);
    check_read("R1 R2 read word 40", 6'd40);

    cmd_erase(6'd3);
    check_read("R3 erased word 3", 6'd3);
    check_read("R3 word 40 kept", 6'd40);

    cmd_wral(4'b0110, 16'h5AA5);
    check_read("R4 write-all word 0", 6'd0);
    check_read("R4 write-all word 3", 6'd3);
    check_read("R4 write-all word 63", 6'd63);
    cmd_write(6'd63, 16'h8001);
    check_read("R1 read word 63", 6'd63);

    // R5: latch cleared again
    cmd_latch(1'b0, 4'b1111);
    cmd_erase(6'd63);
    cmd_write(6'd0, 16'h0000);
    cmd_wral(4'b0000, 16'h1111);
    cmd_eral(4'b0000);
    check_read("R5 word 63 kept", 6'd63);
    check_read("R5 word 0 kept", 6'd0);
    check_read("R5 word 20 kept", 6'd20);

    // R8: aborted write and erase
    cmd_latch(1'b1, 4'b0000);
    open_sel();
    send9(2'b01, 6'd7);
    for (int i = 0; i < 8; i++) sbit(1'b0, s);
    close_sel();
    check_read("R8 aborted write", 6'd7);
    open_sel();
    sbit(1'b1, s); sbit(1'b1, s); sbit(1'b1, s); sbit(1'b0, s); sbit(1'b1, s);
    close_sel();
    check_read("R8 aborted erase", 6'd5);

    // R9: leading zeros before start bit
    open_sel();
    sbit(1'b0, s); sbit(1'b0, s); sbit(1'b0, s);
    send9(2'b10, 6'd63);
    for (int i = 15; i >= 0; i--) begin sbit(1'b0, s); v[i] = s; end
    close_sel();
    chk("R9 read after leading zeros", v, ref_mem[63]);

    // R6: reselect while still busy
    open_sel();
    send9(2'b01, 6'd10);
    send16(16'hC0DE);
    close_sel();
    open_sel();
    expect_status("R6 reselect during job", TW - 2 * H - 6);
    ref_mem[10] = 16'hC0DE;
    check_read("R6 R2 word 10 after reselect", 6'd10);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule